// File: doc/BRIEF.md
# Machine State Register Update Unit

This block owns a core's 64-bit machine state register and is the only path by which software changes it. Each write passes through a fixed chain of rules: bits the core does not implement are cleared, the hypervisor bit is protected, side-effect pulses are raised by comparing the new value with the old one, and, on server-class cores, entering problem state forces the interrupt and translation enables on. The result is loaded on the next clock edge.

From the registered value the block derives, without further delay, one 3-bit translation-mode index for instruction fetch and one for data access, a packed flags word for the execution front end, and a registered exception vector prefix. A small state machine with two states, `ST_RUN` and `ST_HALT`, turns a write that sets the power-save bit into a halt request. `ST_RUN` moves to `ST_HALT` on a write that leaves power-save set while no interrupt is pending and power saving is allowed. `ST_HALT` returns to `ST_RUN` when an interrupt becomes pending or when a write no longer asks for a halt. Configuration straps select hypervisor capability, embedded or server translation style, shadow-register support and server-class enforcement.

Top module: `msr_ctrl`

## Requirements
- R1: During and right after reset the register holds zero except the hypervisor bit (60), which equals the hypervisor-capable strap; both pulses, the halt request and the vector prefix are 0.
- R2: A written value is first ANDed with the implemented-bits mask (default 0x9000_0000_1006_C071, so bit 1 always reads 0).
- R3: The hypervisor bit takes the written value only when the alter-hypervisor input is 1 and the current hypervisor bit is 1; otherwise it keeps its old value.
- R4: The translation-change pulse is 1 for exactly the cycle after a write whose masked, hypervisor-protected value differs from the old register in bit 5 (instruction translation) or bit 4 (data translation), or, in embedded style only, in bit 28 (guest state); bits forced by R7 are not part of that comparison.
- R5: With shadow support strapped on, a write that toggles bit 17 gives a one-cycle swap pulse in the cycle after the write; with the strap off it gives none.
- R6: The exception vector prefix is 0xFFF0_0000 while bit 6 is 1 and 0 while it is 0, updated at the write edge.
- R7: With server-class enforcement on, a written value with bit 14 (problem state) at 1 is stored with bits 15, 5 and 4 set as well; with enforcement off no bit is forced.
- R8: In server style each index is {bit 60, NOT translation enable of its side (bit 5 instruction, bit 4 data), NOT bit 14}.
- R9: In embedded style each index is {bit 28, address-space bit of its side (bit 5 instruction, bit 4 data), NOT bit 14}.
- R10: The flags word is {bit 63 at [8], data index at [7:5], instruction index at [4:2], hypervisor flag at [1], bit 14 at [0]}; the hypervisor flag is 1 on a core without hypervisor capability, else bit 60.
- R11: The halt request rises the cycle after a write that leaves bit 18 set while the pending-interrupt input is 0 and the power-save-permitted input is 1; it falls the cycle after an interrupt is pending or after a write that does not meet that condition.
- R12: The register changes only on a clock edge at which the write strobe is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Value software writes |
| alter_hv_i | input | 1 | Write may alter the hypervisor bit |
| hv_cap_i | input | 1 | Strap: core has a hypervisor mode |
| embedded_i | input | 1 | Strap: embedded translation style (0 = server) |
| shadow_en_i | input | 1 | Strap: shadow copies of GPR0..GPR3 exist |
| server_cls_i | input | 1 | Strap: enforce the problem-state rule |
| irq_pend_i | input | 1 | An interrupt is pending |
| pow_ok_i | input | 1 | Power saving is permitted |
| msr_o | output | 64 | Current register value |
| imode_o | output | 3 | Instruction-side translation mode index |
| dmode_o | output | 3 | Data-side translation mode index |
| flags_o | output | 9 | Packed flags word |
| exc_prefix_o | output | 32 | Exception vector prefix |
| swap_pulse_o | output | 1 | One-cycle shadow-register swap request |
| xlat_chg_o | output | 1 | One-cycle translation-change notice |
| halt_req_o | output | 1 | Halt request |

## Verification
A fault in the write rules shows on `msr_o` one cycle after the write and, through the indices and flags, in the same cycle, so every check samples exactly one edge after the strobe. Pulse faults are visible only in that single cycle; a missing or extra pulse can never be seen later, which is why the pulses are checked on every write, including writes whose forced bits would hide a comparison against the wrong value. A halt state stuck in `ST_HALT` shows as a request that outlives an interrupt by more than one cycle.

// File: rtl/msr_pkg.sv
package msr_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } halt_state_t;

    localparam int FLAG_W  = 9;
    localparam int MODE_W  = 3;

endpackage

// File: rtl/msr_next_calc.sv
module msr_next_calc #(
    parameter int              MSR_W     = 64,
    parameter logic [MSR_W-1:0] IMPL_MASK = 64'h9000_0000_1006_C071,
    parameter int B_HV   = 60,
    parameter int B_GS   = 28,
    parameter int B_TGPR = 17,
    parameter int B_EE   = 15,
    parameter int B_PR   = 14,
    parameter int B_EP   = 6,
    parameter int B_IR   = 5,
    parameter int B_DR   = 4
) (
    input  logic [MSR_W-1:0] cur_i,
    input  logic [MSR_W-1:0] wdata_i,
    input  logic             alter_hv_i,
    input  logic             embedded_i,
    input  logic             shadow_en_i,
    input  logic             server_cls_i,
    output logic [MSR_W-1:0] nxt_o,
    output logic             xlat_chg_o,
    output logic             swap_o,
    output logic             ep_chg_o
);

    logic [MSR_W-1:0] masked;
    logic [MSR_W-1:0] delta;

    always_comb begin
        masked = wdata_i & IMPL_MASK;
        if (!(alter_hv_i && cur_i[B_HV])) begin
            masked[B_HV] = cur_i[B_HV];
        end
        // side effects compare before the problem-state forcing
        delta      = masked ^ cur_i;
        xlat_chg_o = delta[B_IR] | delta[B_DR] | (embedded_i & delta[B_GS]);
        swap_o     = shadow_en_i & delta[B_TGPR];
        ep_chg_o   = delta[B_EP];
        nxt_o      = masked;
        if (server_cls_i && masked[B_PR]) begin
            nxt_o[B_EE] = 1'b1;
            nxt_o[B_IR] = 1'b1;
            nxt_o[B_DR] = 1'b1;
        end
    end

endmodule

// File: rtl/msr_mode_enc.sv
module msr_mode_enc (
    input  logic       embedded_i,
    input  logic       pr_i,
    input  logic       hv_i,
    input  logic       gs_i,
    input  logic       xlat_en_i,
    input  logic       space_i,
    output logic [2:0] idx_o
);

    always_comb begin
        idx_o[0] = ~pr_i;
        if (embedded_i) begin
            idx_o[2] = gs_i;
            idx_o[1] = space_i;
        end else begin
            idx_o[2] = hv_i;
            idx_o[1] = ~xlat_en_i;
        end
    end

endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
    import msr_pkg::*;
#(
    parameter int               MSR_W     = 64,
    parameter logic [MSR_W-1:0] IMPL_MASK = 64'h9000_0000_1006_C071,
    parameter int               PFX_W     = 32,
    parameter logic [PFX_W-1:0] PFX_VAL   = 32'hFFF0_0000,
    parameter int B_SF   = 63,
    parameter int B_HV   = 60,
    parameter int B_GS   = 28,
    parameter int B_POW  = 18,
    parameter int B_TGPR = 17,
    parameter int B_EE   = 15,
    parameter int B_PR   = 14,
    parameter int B_EP   = 6,
    parameter int B_IR   = 5,
    parameter int B_DR   = 4,
    parameter int B_IS   = 5,
    parameter int B_DS   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [MSR_W-1:0]   wr_data_i,
    input  logic               alter_hv_i,
    input  logic               hv_cap_i,
    input  logic               embedded_i,
    input  logic               shadow_en_i,
    input  logic               server_cls_i,
    input  logic               irq_pend_i,
    input  logic               pow_ok_i,
    output logic [MSR_W-1:0]   msr_o,
    output logic [MODE_W-1:0]  imode_o,
    output logic [MODE_W-1:0]  dmode_o,
    output logic [FLAG_W-1:0]  flags_o,
    output logic [PFX_W-1:0]   exc_prefix_o,
    output logic               swap_pulse_o,
    output logic               xlat_chg_o,
    output logic               halt_req_o
);

    localparam int NSIDE = 2;

    logic [MSR_W-1:0] msr_q;
    logic [MSR_W-1:0] nxt;
    logic             xlat_d, swap_d, ep_chg;
    logic             swap_q, xlat_q;
    logic [PFX_W-1:0] pfx_q;
    logic             halt_cond;
    halt_state_t      state_q, state_d;
    logic [MODE_W-1:0] idx [NSIDE];

    msr_next_calc #(
        .MSR_W(MSR_W), .IMPL_MASK(IMPL_MASK),
        .B_HV(B_HV), .B_GS(B_GS), .B_TGPR(B_TGPR), .B_EE(B_EE),
        .B_PR(B_PR), .B_EP(B_EP), .B_IR(B_IR), .B_DR(B_DR)
    ) u_next (
        .cur_i       (msr_q),
        .wdata_i     (wr_data_i),
        .alter_hv_i  (alter_hv_i),
        .embedded_i  (embedded_i),
        .shadow_en_i (shadow_en_i),
        .server_cls_i(server_cls_i),
        .nxt_o       (nxt),
        .xlat_chg_o  (xlat_d),
        .swap_o      (swap_d),
        .ep_chg_o    (ep_chg)
    );

    // register, pulses and prefix
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_q       <= '0;
            msr_q[B_HV] <= hv_cap_i;
            swap_q      <= 1'b0;
            xlat_q      <= 1'b0;
            pfx_q       <= '0;
        end else begin
            swap_q <= wr_en_i & swap_d;
            xlat_q <= wr_en_i & xlat_d;
            if (wr_en_i) begin
                msr_q <= nxt;
                if (ep_chg) begin
                    pfx_q <= nxt[B_EP] ? PFX_VAL : '0;
                end
            end
        end
    end

    // per-side mode index encoders
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam int XB = (s == 0) ? B_IR : B_DR;
        localparam int SB = (s == 0) ? B_IS : B_DS;
        msr_mode_enc u_enc (
            .embedded_i(embedded_i),
            .pr_i      (msr_q[B_PR]),
            .hv_i      (msr_q[B_HV]),
            .gs_i      (msr_q[B_GS]),
            .xlat_en_i (msr_q[XB]),
            .space_i   (msr_q[SB]),
            .idx_o     (idx[s])
        );
    end

    // halt state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign halt_cond = nxt[B_POW] & ~irq_pend_i & pow_ok_i;

    // halt state machine: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wr_en_i && halt_cond) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (irq_pend_i || (wr_en_i && !halt_cond)) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign msr_o        = msr_q;
    assign imode_o      = idx[0];
    assign dmode_o      = idx[1];
    assign exc_prefix_o = pfx_q;
    assign swap_pulse_o = swap_q;
    assign xlat_chg_o   = xlat_q;
    assign halt_req_o   = (state_q == ST_HALT);
    assign flags_o      = {msr_q[B_SF], idx[1], idx[0],
                           (~hv_cap_i) | msr_q[B_HV], msr_q[B_PR]};

endmodule

// File: rtl/msr_ctrl_chk.sv
module msr_ctrl_chk #(
    parameter int               MSR_W     = 64,
    parameter logic [MSR_W-1:0] IMPL_MASK = 64'h9000_0000_1006_C071,
    parameter int               PFX_W     = 32,
    parameter logic [PFX_W-1:0] PFX_VAL   = 32'hFFF0_0000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             alter_hv_i,
    input logic             server_cls_i,
    input logic             wr_pr_i,
    input logic [MSR_W-1:0] msr_o,
    input logic             hv_bit,
    input logic             pow_bit,
    input logic             ep_bit,
    input logic             ee_bit,
    input logic             ir_bit,
    input logic             dr_bit,
    input logic [PFX_W-1:0] exc_prefix_o,
    input logic             swap_pulse_o,
    input logic             xlat_chg_o,
    input logic             halt_req_o
);

    // R2
    impl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_o & ~IMPL_MASK) == '0);

    // R3
    hv_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !(alter_hv_i && hv_bit)) |=> (hv_bit == $past(hv_bit)));

    // R4
    xlat_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_chg_o |-> $past(wr_en_i));

    // R5
    swap_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse_o |-> $past(wr_en_i));

    // R6
    prefix_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_prefix_o == (ep_bit ? PFX_VAL : '0));

    // R7
    pr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && server_cls_i && wr_pr_i) |=> (ee_bit && ir_bit && dr_bit));

    // R11
    halt_has_pow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_o |-> pow_bit);

    // R12
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> $stable(msr_o));

endmodule

bind msr_ctrl msr_ctrl_chk #(
    .MSR_W(MSR_W), .IMPL_MASK(IMPL_MASK), .PFX_W(PFX_W), .PFX_VAL(PFX_VAL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .alter_hv_i  (alter_hv_i),
    .server_cls_i(server_cls_i),
    .wr_pr_i     (wr_data_i[B_PR]),
    .msr_o       (msr_o),
    .hv_bit      (msr_o[B_HV]),
    .pow_bit     (msr_o[B_POW]),
    .ep_bit      (msr_o[B_EP]),
    .ee_bit      (msr_o[B_EE]),
    .ir_bit      (msr_o[B_IR]),
    .dr_bit      (msr_o[B_DR]),
    .exc_prefix_o(exc_prefix_o),
    .swap_pulse_o(swap_pulse_o),
    .xlat_chg_o  (xlat_chg_o),
    .halt_req_o  (halt_req_o)
);

// File: tb/test_msr_ctrl.sv
`timescale 1ns/1ps
module test_msr_ctrl;

    localparam logic [63:0] SF   = 64'h1 << 63;
    localparam logic [63:0] HV   = 64'h1 << 60;
    localparam logic [63:0] GS   = 64'h1 << 28;
    localparam logic [63:0] POW  = 64'h1 << 18;
    localparam logic [63:0] TGPR = 64'h1 << 17;
    localparam logic [63:0] EE   = 64'h1 << 15;
    localparam logic [63:0] PR   = 64'h1 << 14;
    localparam logic [63:0] EP   = 64'h1 << 6;
    localparam logic [63:0] IR   = 64'h1 << 5;
    localparam logic [63:0] DR   = 64'h1 << 4;

    typedef struct packed {
        logic [63:0] data;
        logic        alter;
        logic [63:0] e_msr;
        logic        e_xlat;
        logic        e_swap;
        logic [31:0] e_pfx;
        logic [2:0]  e_im;
        logic [2:0]  e_dm;
    } vec_t;

    // server style, hypervisor-capable, shadow on, server-class on
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{64'h3 , 1'b0, HV | 64'h1,     1'b0, 1'b0, 32'h0,         3'd7, 3'd7},
        '{64'h30, 1'b0, HV | 64'h30,    1'b1, 1'b0, 32'h0,         3'd5, 3'd5},
        '{64'h20030, 1'b0, HV | 64'h20030, 1'b0, 1'b1, 32'h0,      3'd5, 3'd5},
        '{64'h30, 1'b0, HV | 64'h30,    1'b0, 1'b1, 32'h0,         3'd5, 3'd5},
        '{64'h70, 1'b0, HV | 64'h70,    1'b0, 1'b0, 32'hFFF0_0000, 3'd5, 3'd5},
        '{64'h0 , 1'b1, 64'h0,          1'b1, 1'b0, 32'h0,         3'd3, 3'd3},
        '{HV    , 1'b1, 64'h0,          1'b0, 1'b0, 32'h0,         3'd3, 3'd3},
        '{64'h4000, 1'b0, 64'hC030,     1'b0, 1'b0, 32'h0,         3'd0, 3'd0},
        '{64'h10, 1'b0, 64'h10,         1'b1, 1'b0, 32'h0,         3'd3, 3'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        alter_hv = 1'b0;
    logic        hv_cap = 1'b1, embedded = 1'b0, shadow_en = 1'b1, server_cls = 1'b1;
    logic        irq_pend = 1'b0, pow_ok = 1'b0;
    logic [63:0] msr;
    logic [2:0]  imode, dmode;
    logic [8:0]  flags;
    logic [31:0] pfx;
    logic        swap_p, xlat_p, halt_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msr_ctrl i_msr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .alter_hv_i(alter_hv), .hv_cap_i(hv_cap), .embedded_i(embedded),
        .shadow_en_i(shadow_en), .server_cls_i(server_cls),
        .irq_pend_i(irq_pend), .pow_ok_i(pow_ok),
        .msr_o(msr), .imode_o(imode), .dmode_o(dmode), .flags_o(flags),
        .exc_prefix_o(pfx), .swap_pulse_o(swap_p), .xlat_chg_o(xlat_p),
        .halt_req_o(halt_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic hv, input logic emb, input logic shd, input logic srv);
        @(negedge clk);
        hv_cap = hv; embedded = emb; shadow_en = shd; server_cls = srv;
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at a falling edge, results sampled at the next falling edge
    task automatic do_write(input logic [63:0] d, input logic alt);
        wr_en = 1'b1; wr_data = d; alter_hv = alt;
        @(negedge clk);
        wr_en = 1'b0; alter_hv = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R1 reset state, hypervisor-capable
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        check("R1 msr", msr, HV);
        check("R1 pulses/halt", {61'b0, swap_p, xlat_p, halt_req}, 64'h0);
        check("R1 prefix", {32'b0, pfx}, 64'h0);

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int k = 0; k < NV; k++) begin
            do_write(VECS[k].data, VECS[k].alter);
            check($sformatf("R2/R3/R7 msr vec%0d", k), msr, VECS[k].e_msr);
            check($sformatf("R4 xlat vec%0d", k), {63'b0, xlat_p}, {63'b0, VECS[k].e_xlat});
            check($sformatf("R5 swap vec%0d", k), {63'b0, swap_p}, {63'b0, VECS[k].e_swap});
            check($sformatf("R6 prefix vec%0d", k), {32'b0, pfx}, {32'b0, VECS[k].e_pfx});
            check($sformatf("R8 modes vec%0d", k), {58'b0, imode, dmode},
                  {58'b0, VECS[k].e_im, VECS[k].e_dm});
        end
        // R4 pulse lasts one cycle, R12 no change without a write
        @(negedge clk);
        check("R4 pulse single cycle", {63'b0, xlat_p}, 64'h0);
        check("R12 hold", msr, 64'h10);

        // R10 flags with 64-bit mode bit in server style
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        do_write(SF, 1'b0);
        check("R10 msr", msr, SF | HV);
        check("R10 flags server", {55'b0, flags}, 64'h1FE);

        // R4 guest-state change in server style gives no pulse
        do_write(SF | GS, 1'b0);
        check("R4 gs server no pulse", {63'b0, xlat_p}, 64'h0);

        // R1 R9 R10 R4 embedded, no hypervisor capability
        do_reset(1'b0, 1'b1, 1'b1, 1'b1);
        check("R1 msr no hv", msr, 64'h0);
        do_write(GS, 1'b0);
        check("R4 gs embedded pulse", {63'b0, xlat_p}, 64'h1);
        check("R9 modes gs", {58'b0, imode, dmode}, {58'b0, 3'd5, 3'd5});
        check("R10 flags hv forced", {55'b0, flags}, 64'h0B6);
        do_write(GS | DR, 1'b0);
        check("R9 modes ds", {58'b0, imode, dmode}, {58'b0, 3'd5, 3'd7});

        // R5 R7 with straps off
        do_reset(1'b1, 1'b0, 1'b0, 1'b0);
        do_write(TGPR, 1'b0);
        check("R5 no swap when strap off", {63'b0, swap_p}, 64'h0);
        do_write(PR, 1'b0);
        check("R7 no force when off", msr, HV | PR);

        // R11 halt state machine
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        pow_ok = 1'b1;
        do_write(POW, 1'b0);
        check("R11 halt enter", {63'b0, halt_req}, 64'h1);
        irq_pend = 1'b1;
        @(negedge clk);
        check("R11 halt exit on irq", {63'b0, halt_req}, 64'h0);
        do_write(POW, 1'b0);
        check("R11 no halt while irq", {63'b0, halt_req}, 64'h0);
        irq_pend = 1'b0; pow_ok = 1'b0;
        do_write(POW | EE, 1'b0);
        check("R11 no halt unpermitted", {63'b0, halt_req}, 64'h0);
        pow_ok = 1'b1;
        do_write(POW, 1'b0);
        check("R11 halt again", {63'b0, halt_req}, 64'h1);
        do_write(64'h0, 1'b0);
        check("R11 halt exit on write", {63'b0, halt_req}, 64'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule